// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block turns an idle-high asynchronous serial line back into parallel words. The frame layout is chosen at run time: 5 to 8 data bits, either bit order, and no parity, even parity or odd parity. Stop length is not a setting of the receiver. Only the first stop bit is examined, so a frame with one, one and a half or two stop periods is accepted the same way. The layout inputs must stay stable while a frame is in flight.

The line passes through a two-flop synchronizer. The block then watches for a falling edge. After the edge it runs an oversample tick of 16 per bit period, derived from a programmable divisor. Each bit is decided by a majority of three samples taken in oversample slots 7, 8 and 9. A start bit that does not read 0 at its centre is reported as a false start, and the block goes back to idle. A complete frame raises a one-cycle valid pulse with the word, a parity error flag and a framing error flag. The receiver then re-arms at once for the next falling edge.

Top module: `uart_frame_rx`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `valid_o` and `false_start_o` are 0 and `data_o`, `parity_err_o` and `frame_err_o` are 0.
- R2: Define P = `div_i`+1 and S = the index of the first stop bit, where the start bit is index 0, so S = 1 + length + (1 if parity is enabled). Define t0 as the clock edge after which the line falls. Then `valid_o` is high for exactly the one cycle that follows edge t0 + 3 + (16·S + 10)·P, and is low at every other time.
- R3: With `msb_first_i`=0, the first data bit received lands in `data_o[0]` and later bits land in rising positions.
- R4: With `msb_first_i`=1, the first data bit received lands in `data_o[n-1]`, where n is the data length.
- R5: `data_len_i` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The bits of `data_o` above the selected length read 0.
- R6: `par_mode_i` selects the parity check: 0 or 3 means no parity bit and `parity_err_o` is 0; 1 means even; 2 means odd. In even mode, `parity_err_o` is set when the ones in the data bits plus the parity bit add up to an odd count. In odd mode, it is set when they add up to an even count.
- R7: When the first stop bit votes 0, `frame_err_o` is set and the valid pulse still fires with the word.
- R8: When the start bit votes 1 at its centre, `false_start_o` pulses for one cycle after edge t0 + 3 + 10·P. No valid pulse follows, and the block returns to idle.
- R9: Each bit is the majority of three samples taken in oversample slots 7, 8 and 9. One disturbed sample does not change the bit.
- R10: `data_o`, `parity_err_o` and `frame_err_o` change only with a valid pulse and hold their values between pulses. `valid_o` and `false_start_o` are never high together.
- R11: A new start bit that begins right at the end of a one-period stop bit is received as a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| div_i | input | DIV_W | Oversample divisor; one tick every `div_i`+1 clocks |
| data_len_i | input | 2 | Data length select, 5 + value bits |
| par_mode_i | input | 2 | 0/3 none, 1 even, 2 odd |
| msb_first_i | input | 1 | 1: first data bit is the most significant bit |
| data_o | output | 8 | Received word, right-aligned |
| valid_o | output | 1 | One-cycle pulse when a word is presented |
| parity_err_o | output | 1 | Parity mismatch of the word presented |
| frame_err_o | output | 1 | First stop bit read 0 |
| false_start_o | output | 1 | One-cycle pulse on an abandoned start |

## Verification
The parity check and the stop-bit check are both decided on the same valid pulse. The bench provokes this with an odd-parity frame whose parity bit is inverted and whose stop bit is driven low. It then expects `parity_err_o` and `frame_err_o` both set in the one cycle predicted by R2, with the correct word beside them. A behavioural model predicts the exact cycle of every pulse, and every clock is compared against it. This catches a late or missing pulse as well as a wrong flag.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;
  localparam logic [3:0] OS_S0   = 4'd7;
  localparam logic [3:0] OS_S1   = 4'd8;
  localparam logic [3:0] OS_DEC  = 4'd9;
  localparam logic [3:0] OS_LAST = 4'd15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);
  // two sync stages plus one history stage, all reset to idle level
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[1:0], rx_i};
  end

  assign rx_s_o = sh_q[1];
  assign fall_o = sh_q[2] & ~sh_q[1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [3:0]       os_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [3:0]       os_q;

  assign tick_o = run_i && (cnt_q == div_i);
  assign os_o   = os_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      os_q  <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      os_q  <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
      os_q  <= os_q + 4'd1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en0_i,
  input  logic en1_i,
  input  logic bit_i,
  output logic vote_o
);
  logic s0_q, s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= 1'b1;
      s1_q <= 1'b1;
    end else begin
      if (en0_i) s0_q <= bit_i;
      if (en1_i) s1_q <= bit_i;
    end
  end

  // third sample is the live one at decision time
  assign vote_o = (s0_q & s1_q) | (s0_q & bit_i) | (s1_q & bit_i);
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int DIV_W = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               rx_i,
  input  logic [DIV_W-1:0]                   div_i,
  input  logic [1:0]                         data_len_i,
  input  logic [1:0]                         par_mode_i,
  input  logic                               msb_first_i,
  output logic [uart_rx_pkg::DATA_W-1:0]     data_o,
  output logic                               valid_o,
  output logic                               parity_err_o,
  output logic                               frame_err_o,
  output logic                               false_start_o
);
  import uart_rx_pkg::*;

  localparam int IDX_W = $clog2(DATA_W);

  rx_state_e         state_q;
  logic [IDX_W-1:0]  bit_q;
  logic [DATA_W-1:0] word_q;
  logic              par_q;

  logic       rx_s, fall, tick, vote, run, dec, bit_end, par_en, ones, perr;
  logic [3:0] os;
  logic [IDX_W-1:0] last_idx, put_idx;

  assign run      = (state_q != ST_IDLE);
  assign dec      = tick && (os == OS_DEC);
  assign bit_end  = tick && (os == OS_LAST);
  assign last_idx = IDX_W'(4) + IDX_W'(data_len_i);
  assign put_idx  = msb_first_i ? (last_idx - bit_q) : bit_q;
  assign par_en   = (par_mode_i == 2'd1) || (par_mode_i == 2'd2);
  assign ones     = ^{word_q, par_q};
  assign perr     = par_en && ((par_mode_i == 2'd2) ? ~ones : ones);

  uart_rx_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .rx_s_o (rx_s),
    .fall_o (fall)
  );

  uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_i),
    .tick_o (tick),
    .os_o   (os)
  );

  uart_rx_vote u_vote (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en0_i  (tick && (os == OS_S0)),
    .en1_i  (tick && (os == OS_S1)),
    .bit_i  (rx_s),
    .vote_o (vote)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      bit_q         <= '0;
      word_q        <= '0;
      par_q         <= 1'b0;
      data_o        <= '0;
      valid_o       <= 1'b0;
      parity_err_o  <= 1'b0;
      frame_err_o   <= 1'b0;
      false_start_o <= 1'b0;
    end else begin
      valid_o       <= 1'b0;
      false_start_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fall) begin
          state_q <= ST_START;
          bit_q   <= '0;
          word_q  <= '0;
          par_q   <= 1'b0;
        end
        ST_START: begin
          if (dec && vote) begin
            false_start_o <= 1'b1;
            state_q       <= ST_IDLE;
          end else if (bit_end) begin
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (dec) word_q[put_idx] <= vote;
          if (bit_end) begin
            if (bit_q == last_idx) state_q <= par_en ? ST_PAR : ST_STOP;
            else                   bit_q   <= bit_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (dec)     par_q   <= vote;
          if (bit_end) state_q <= ST_STOP;
        end
        ST_STOP: if (dec) begin
          // only the first stop bit is judged; re-arm right away
          valid_o      <= 1'b1;
          data_o       <= word_q;
          parity_err_o <= perr;
          frame_err_o  <= ~vote;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] data_len_i,
  input logic [1:0] par_mode_i,
  input logic [7:0] data_o,
  input logic       valid_o,
  input logic       parity_err_o,
  input logic       frame_err_o,
  input logic       false_start_o
);
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !false_start_o); // R10

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R2

  AST_FALSE_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    false_start_o |=> !false_start_o); // R8

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o)); // R10

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(parity_err_o) && $stable(frame_err_o))); // R10

  AST_NO_PARITY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (par_mode_i == 2'd0 || par_mode_i == 2'd3)) |-> !parity_err_o); // R6

  AST_SHORT_WORD_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && data_len_i == 2'd0) |-> (data_o[7:5] == 3'b000)); // R5
endmodule

bind uart_frame_rx uart_frame_rx_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .data_len_i    (data_len_i),
  .par_mode_i    (par_mode_i),
  .data_o        (data_o),
  .valid_o       (valid_o),
  .parity_err_o  (parity_err_o),
  .frame_err_o   (frame_err_o),
  .false_start_o (false_start_o)
);

// File: tb/sim_uart_frame_rx.sv
module sim_uart_frame_rx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_i = 1'b1;
  logic [15:0] div_i = 16'd3;
  logic [1:0]  data_len_i = 2'd3;
  logic [1:0]  par_mode_i = 2'd0;
  logic        msb_first_i = 1'b0;
  logic [7:0]  data_o;
  logic        valid_o, parity_err_o, frame_err_o, false_start_o;

  uart_frame_rx #(.DIV_W(16)) u0 (
    .clk_i, .rst_ni, .rx_i, .div_i, .data_len_i, .par_mode_i, .msb_first_i,
    .data_o, .valid_o, .parity_err_o, .frame_err_o, .false_start_o
  );

  always #2 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  typedef struct {
    int         at;
    bit         fs;
    logic [7:0] d;
    bit         pe;
    bit         fe;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  logic [7:0] hold_d = 8'h00;
  bit hold_pe = 1'b0, hold_fe = 1'b0;
  bit armed = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, expv, cyc);
    end
  endtask

  // per-clock comparison against the predicted pulse schedule
  always @(negedge clk_i) begin
    exp_t e;
    if (armed) begin
      if (q.size() > 0 && q[0].at == cyc) begin
        e = q.pop_front();
        if (e.fs) begin
          chk(false_start_o == 1'b1, e.tag, "false start pulse", int'(false_start_o), 1);
          chk(valid_o == 1'b0, e.tag, "no valid on false start", int'(valid_o), 0);
        end else begin
          chk(valid_o == 1'b1, e.tag, "valid pulse", int'(valid_o), 1);
          chk(data_o == e.d, e.tag, "data", int'(data_o), int'(e.d));
          chk(parity_err_o == e.pe, e.tag, "parity flag", int'(parity_err_o), int'(e.pe));
          chk(frame_err_o == e.fe, e.tag, "framing flag", int'(frame_err_o), int'(e.fe));
          hold_d = e.d; hold_pe = e.pe; hold_fe = e.fe;
        end
      end else begin
        chk(!valid_o && !false_start_o, "R2", "no pulse expected",
            {valid_o, false_start_o}, 0);
        chk(data_o == hold_d && parity_err_o == hold_pe && frame_err_o == hold_fe,
            "R10", "hold between pulses", {parity_err_o, frame_err_o, data_o},
            {hold_pe, hold_fe, hold_d});
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic drive_bit(input logic v, input bit glitch);
    int p;
    p = int'(div_i) + 1;
    for (int c = 0; c < 16 * p; c++) begin
      rx_i = (glitch && c == 9 * p) ? ~v : v;
      step(1);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit badpar, input bit badstop,
                      input int gl_bit, input string tag);
    int p, n, si;
    bit pen, pb;
    logic [7:0] dm;
    exp_t e;
    p   = int'(div_i) + 1;
    n   = 5 + int'(data_len_i);
    pen = (par_mode_i == 2'd1) || (par_mode_i == 2'd2);
    dm  = d & 8'((1 << n) - 1);
    pb  = ^dm;
    if (par_mode_i == 2'd2) pb = ~pb;
    if (badpar) pb = ~pb;
    si  = 1 + n + (pen ? 1 : 0);
    e.at = cyc + 3 + (16 * si + 10) * p;
    e.fs = 1'b0; e.d = dm; e.pe = badpar && pen; e.fe = badstop; e.tag = tag;
    q.push_back(e);
    drive_bit(1'b0, 1'b0);
    for (int k = 0; k < n; k++)
      drive_bit(msb_first_i ? dm[n-1-k] : dm[k], gl_bit == k);
    if (pen) drive_bit(pb, 1'b0);
    drive_bit(~badstop, 1'b0);
    rx_i = 1'b1;
  endtask

  task automatic false_start(input string tag);
    int p;
    exp_t e;
    p = int'(div_i) + 1;
    e.at = cyc + 3 + 10 * p; e.fs = 1'b1; e.d = 8'h00; e.pe = 1'b0; e.fe = 1'b0; e.tag = tag;
    q.push_back(e);
    rx_i = 1'b0;
    step(3 * p);
    rx_i = 1'b1;
    step(16 * p);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0 pending", q.size());
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(4);
    @(negedge clk_i);
    chk(!valid_o && !false_start_o && data_o == 8'h00 && !parity_err_o && !frame_err_o,
        "R1", "reset state", {valid_o, false_start_o, parity_err_o, frame_err_o, data_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!valid_o && !false_start_o && data_o == 8'h00, "R1", "after release",
        {valid_o, false_start_o, data_o}, 0);
    armed = 1'b1;
    step(8);

    // R3: LSB-first, 8 bits, no parity
    send(8'h41, 1'b0, 1'b0, -1, "R3"); step(20);
    send(8'hC6, 1'b0, 1'b0, -1, "R3"); step(20);
    // R4: MSB-first, 8 bits
    msb_first_i = 1'b1;
    send(8'h41, 1'b0, 1'b0, -1, "R4"); step(20);
    // R5: 6-bit MSB-first, then 5-bit LSB-first with upper bits set in the stimulus
    data_len_i = 2'd1;
    send(8'h2B, 1'b0, 1'b0, -1, "R5"); step(20);
    msb_first_i = 1'b0; data_len_i = 2'd0;
    send(8'hF5, 1'b0, 1'b0, -1, "R5"); step(20);
    data_len_i = 2'd2;
    send(8'h5A, 1'b0, 1'b0, -1, "R5"); step(20);
    // R6: even good, odd good, odd bad, even bad, mode 3 as none
    data_len_i = 2'd3; par_mode_i = 2'd1;
    send(8'h41, 1'b0, 1'b0, -1, "R6"); step(20);
    par_mode_i = 2'd2;
    send(8'h41, 1'b0, 1'b0, -1, "R6"); step(20);
    send(8'h37, 1'b1, 1'b0, -1, "R6"); step(20);
    par_mode_i = 2'd1;
    send(8'h80, 1'b1, 1'b0, -1, "R6"); step(20);
    par_mode_i = 2'd3;
    send(8'h99, 1'b1, 1'b0, -1, "R6"); step(20);
    // R7: stop low, then parity and framing errors together
    par_mode_i = 2'd0;
    send(8'h3C, 1'b0, 1'b1, -1, "R7"); step(20);
    par_mode_i = 2'd2;
    send(8'hE1, 1'b1, 1'b1, -1, "R7"); step(20);
    // R8: short low pulse abandoned, then a normal frame still received
    par_mode_i = 2'd0;
    false_start("R8");
    send(8'h12, 1'b0, 1'b0, -1, "R8"); step(20);
    // R9: one disturbed centre sample in data bit 2
    send(8'hA5, 1'b0, 1'b0, 2, "R9"); step(20);
    send(8'h00, 1'b0, 1'b0, 5, "R9"); step(20);
    // R11: back-to-back frames with a one-period stop, different divisor
    div_i = 16'd5;
    send(8'h55, 1'b0, 1'b0, -1, "R11");
    send(8'hAA, 1'b0, 1'b0, -1, "R11");
    send(8'h0F, 1'b0, 1'b0, -1, "R11"); step(20);
    div_i = 16'd1; par_mode_i = 2'd1;
    send(8'h7E, 1'b0, 1'b0, -1, "R2");
    send(8'h81, 1'b0, 1'b0, -1, "R2"); step(40);

    chk(q.size() == 0, "R2", "all predicted pulses seen", q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule